// File: doc/BRIEF.md
# Host register-access command port

This block is a single-channel command port. It turns 32-bit host register writes into 16-bit read or write transactions toward a remote register file. A downstream serial transfer engine carries each transaction, and the port reaches it through a request/acknowledge/done interface. The host selects one of four host registers with a 2-bit select: 0 is the port enable, 1 is the init-done flag, 2 is the command word and 3 is the valid-clear. The host then polls a 32-bit status word.

A command word holds a write flag in bit 31, where 1 means write and 0 means read. Bits 30:16 hold the halfword address, which is the byte address shifted right by one because the register stride is 2 bytes. Bits 15:0 hold the write data. The port accepts a command only while it is enabled and idle. It raises a request and keeps it up until the engine acknowledges it, then waits for the engine to report completion. A write returns straight to idle. A read parks with its data visible in the status word until the host writes 1 to the valid-clear register.

The status word is laid out as follows:
- bits 15:0 hold the last read data;
- bits 18:16 hold the state code (idle 0, request 2, waiting for the engine 4, holding read data 6);
- bit 19 is set while a request is pending;
- bit 20 is sync-idle;
- bit 21 is init-done.

Top module: `regacc_cmd_port`

## Requirements
- R1: After reset the status word reads 0x0010_0000: state 0, no request pending, sync-idle set, init-done clear, read data zero; the enable register resets to 0.
- R2: On an accepted command, req_write_o carries command bit 31, req_addr_o carries bits 30:16 and req_wdata_o carries bits 15:0. These outputs stay stable while the request is up.
- R3: A command written (select 2) while enabled and idle moves the state to 2 in the next cycle. It sets status bit 19 and holds req_o high until the cycle in which ack_i is seen.
- R4: When ack_i is seen while the request is up, the state becomes 4 in the next cycle and stays there until done_i.
- R5: When done_i arrives for a write, the state returns to 0 in the next cycle.
- R6: When done_i arrives for a read, rdata_i is captured into status bits 15:0 and the state becomes 6. Both the state and the data stay unchanged until a valid-clear.
- R7: A valid-clear write (select 3) with bit 0 set returns state 6 to state 0. With bit 0 clear it has no effect, and in any other state it has no effect.
- R8: A command written while the enable register (select 1 is not it; select 0, bit 0) is 0, or while the state is not 0, is ignored: the state and req_o are unchanged and no extra transaction reaches the engine.
- R9: Status bit 20 (sync-idle) is 1 exactly when eng_busy_i is 0 and no request is pending.
- R10: Status bit 21 follows bit 0 of the last write to the init-done register (select 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_valid | input | 1 | Host register write strobe |
| hw_sel | input | 2 | Host register select: 0 enable, 1 init-done, 2 command, 3 valid-clear |
| hw_data | input | 32 | Host write data |
| status_o | output | 32 | Status word |
| req_o | output | 1 | Transaction request to engine |
| req_write_o | output | 1 | 1 for a write transaction |
| req_addr_o | output | 15 | Halfword address |
| req_wdata_o | output | 16 | Write data |
| ack_i | input | 1 | Engine accepted the request |
| done_i | input | 1 | Engine finished the transaction |
| rdata_i | input | 16 | Read data, valid with done_i |
| eng_busy_i | input | 1 | Engine has a transfer in flight |

## Verification
The checker watches several rules on every cycle:
- only the four legal state codes appear;
- a request holds with a stable address until it is acknowledged;
- an acknowledge leads to the wait state, and a write completion leads to idle;
- held read data stays put until a set valid-clear, which then empties the port;
- a command written while disabled never leaves idle;
- sync-idle drops whenever a request is up.

Only the bench scenarios can show the rest:
- decoded address and data reach the engine intact, in issue order;
- commands written while busy or disabled produce no transaction at all;
- data read back matches what earlier writes stored in the remote file.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  localparam int HOST_W = 32;
  localparam int DATA_W = 16;
  localparam int ADDR_W = HOST_W - DATA_W - 1;
  localparam int SEL_W  = 2;
  localparam int STW    = 3;

  // status word field positions (host software decodes these)
  localparam int ST_LSB   = DATA_W;
  localparam int PEND_BIT = DATA_W + STW;
  localparam int SYNC_BIT = DATA_W + STW + 1;
  localparam int INIT_BIT = DATA_W + STW + 2;

  typedef enum logic [STW-1:0] {
    ST_IDLE      = 3'd0,
    ST_REQ       = 3'd2,
    ST_WAIT_DONE = 3'd4,
    ST_WAIT_VCLR = 3'd6
  } port_state_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_ENABLE = 2'd0,
    SEL_INIT   = 2'd1,
    SEL_CMD    = 2'd2,
    SEL_VCLR   = 2'd3
  } host_sel_e;

  typedef struct packed {
    logic              is_write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [HOST_W-1:0] word);
    cmd_t c;
    c.is_write = word[HOST_W-1];
    c.addr     = word[HOST_W-2:DATA_W];
    c.data     = word[DATA_W-1:0];
    return c;
  endfunction

  function automatic logic [HOST_W-1:0] pack_status(
    input port_state_e       st,
    input logic              pending,
    input logic              sync_idle,
    input logic              init_done,
    input logic [DATA_W-1:0] rdata
  );
    logic [HOST_W-1:0] w;
    w = '0;
    w[DATA_W-1:0]          = rdata;
    w[ST_LSB+STW-1:ST_LSB] = st;
    w[PEND_BIT]            = pending;
    w[SYNC_BIT]            = sync_idle;
    w[INIT_BIT]            = init_done;
    return w;
  endfunction

endpackage

// File: rtl/regacc_host_regs.sv
module regacc_host_regs
  import regacc_pkg::*;
#(
  parameter int HW = HOST_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_valid,
  input  logic [SW-1:0] hw_sel,
  input  logic [HW-1:0] hw_data,
  output logic          enable_q,
  output logic          init_done_q,
  output logic          cmd_wr,
  output logic [HW-1:0] cmd_word,
  output logic          vclr_wr
);

  logic sel_en, sel_init;

  assign sel_en   = hw_valid && (hw_sel == SEL_ENABLE);
  assign sel_init = hw_valid && (hw_sel == SEL_INIT);
  assign cmd_wr   = hw_valid && (hw_sel == SEL_CMD);
  assign vclr_wr  = hw_valid && (hw_sel == SEL_VCLR) && hw_data[0];
  assign cmd_word = hw_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q    <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      if (sel_en)   enable_q    <= hw_data[0];
      if (sel_init) init_done_q <= hw_data[0];
    end
  end

endmodule

// File: rtl/regacc_cmd_fsm.sv
module regacc_cmd_fsm
  import regacc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cmd_wr,
  input  cmd_t          cmd,
  input  logic          vclr_wr,
  input  logic          ack_i,
  input  logic          done_i,
  input  logic [DW-1:0] rdata_i,
  output port_state_e   state_q,
  output logic          cmd_accept,
  output logic          req_o,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  output logic [DW-1:0] rdata_q
);

  port_state_e state_d;
  cmd_t        cur_q;

  assign cmd_accept  = cmd_wr && enable && (state_q == ST_IDLE);
  assign req_o       = (state_q == ST_REQ);
  assign req_write_o = cur_q.is_write;
  assign req_addr_o  = cur_q.addr;
  assign req_wdata_o = cur_q.data;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (cmd_accept) state_d = ST_REQ;
      ST_REQ:       if (ack_i) state_d = ST_WAIT_DONE;
      ST_WAIT_DONE: if (done_i) state_d = cur_q.is_write ? ST_IDLE : ST_WAIT_VCLR;
      ST_WAIT_VCLR: if (vclr_wr) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_accept) cur_q <= cmd;
      if (state_q == ST_WAIT_DONE && done_i && !cur_q.is_write) rdata_q <= rdata_i;
    end
  end

endmodule

// File: rtl/regacc_status_pack.sv
module regacc_status_pack
  import regacc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HOST_W
) (
  input  port_state_e   state,
  input  logic [DW-1:0] rdata,
  input  logic          eng_busy,
  input  logic          init_done,
  output logic          pending,
  output logic          sync_idle,
  output logic [HW-1:0] status
);

  assign pending   = (state == ST_REQ);
  assign sync_idle = !eng_busy && !pending;
  assign status    = pack_status(state, pending, sync_idle, init_done, rdata);

endmodule

// File: rtl/regacc_cmd_port.sv
module regacc_cmd_port
  import regacc_pkg::*;
#(
  parameter int HW = HOST_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_valid,
  input  logic [SW-1:0] hw_sel,
  input  logic [HW-1:0] hw_data,
  output logic [HW-1:0] status_o,
  output logic          req_o,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          ack_i,
  input  logic          done_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          eng_busy_i
);

  logic          enable_q, init_done_q, cmd_wr, vclr_wr, cmd_accept;
  logic          pending, sync_idle;
  logic [HW-1:0] cmd_word;
  logic [DW-1:0] rdata_q;
  port_state_e   state_q;
  cmd_t          cmd;

  assign cmd = decode_cmd(cmd_word);

  regacc_host_regs #(.HW(HW), .SW(SW)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_sel(hw_sel),
    .hw_data(hw_data), .enable_q(enable_q), .init_done_q(init_done_q),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .vclr_wr(vclr_wr)
  );

  regacc_cmd_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .cmd_wr(cmd_wr), .cmd(cmd),
    .vclr_wr(vclr_wr), .ack_i(ack_i), .done_i(done_i), .rdata_i(rdata_i),
    .state_q(state_q), .cmd_accept(cmd_accept), .req_o(req_o),
    .req_write_o(req_write_o), .req_addr_o(req_addr_o),
    .req_wdata_o(req_wdata_o), .rdata_q(rdata_q)
  );

  regacc_status_pack #(.DW(DW), .HW(HW)) u_stat (
    .state(state_q), .rdata(rdata_q), .eng_busy(eng_busy_i),
    .init_done(init_done_q), .pending(pending), .sync_idle(sync_idle),
    .status(status_o)
  );

endmodule

// File: rtl/regacc_cmd_port_chk.sv
module regacc_cmd_port_chk
  import regacc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] status_o,
  input logic        req_o,
  input logic [14:0] req_addr_o,
  input logic        req_write_o,
  input logic        ack_i,
  input logic        done_i,
  input logic        cmd_wr,
  input logic        enable_q,
  input logic        vclr_wr
);

  logic [2:0] st;
  assign st = status_o[ST_LSB+STW-1:ST_LSB];

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 || st == 3'd2 || st == 3'd4 || st == 3'd6)); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(req_addr_o))); // R2

  AST_ACK_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> (st == 3'd4)); // R4

  AST_WRITE_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && done_i && req_write_o) |=> (st == 3'd0)); // R5

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6 && !vclr_wr) |=> (st == 3'd6 && $stable(status_o[15:0]))); // R6

  AST_VCLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6 && vclr_wr) |=> (st == 3'd0)); // R7

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && cmd_wr && !enable_q) |=> (st == 3'd0 && !req_o)); // R8

  AST_SYNC_LOW_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (!status_o[SYNC_BIT] && status_o[PEND_BIT])); // R9

endmodule

bind regacc_cmd_port regacc_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status_o(status_o), .req_o(req_o),
  .req_addr_o(req_addr_o), .req_write_o(req_write_o), .ack_i(ack_i),
  .done_i(done_i), .cmd_wr(cmd_wr), .enable_q(enable_q), .vclr_wr(vclr_wr)
);

// File: tb/test_regacc_cmd_port.sv
`timescale 1ns/1ps
module test_regacc_cmd_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic [1:0]  hw_sel = '0;
  logic [31:0] hw_data = '0;
  logic [31:0] status_o;
  logic        req_o, req_write_o;
  logic [14:0] req_addr_o;
  logic [15:0] req_wdata_o;
  logic        ack_i = 1'b0, done_i = 1'b0, eng_busy_i = 1'b0;
  logic [15:0] rdata_i = '0;

  always #4 clk = ~clk;

  regacc_cmd_port i_regacc_cmd_port (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_sel(hw_sel),
    .hw_data(hw_data), .status_o(status_o), .req_o(req_o),
    .req_write_o(req_write_o), .req_addr_o(req_addr_o),
    .req_wdata_o(req_wdata_o), .ack_i(ack_i), .done_i(done_i),
    .rdata_i(rdata_i), .eng_busy_i(eng_busy_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // remote register file stub and bench-side model
  logic [15:0] remote [16];
  logic [15:0] model  [16];
  logic [14:0] s_addr;
  int          s_cnt = 0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      remote[i] = 16'h1000 + 16'(i) * 16'h0101;
      model[i]  = 16'h1000 + 16'(i) * 16'h0101;
    end
  end

  always @(posedge clk) begin
    ack_i  <= req_o && !ack_i && !eng_busy_i && !done_i;
    done_i <= 1'b0;
    if (ack_i) begin
      eng_busy_i <= 1'b1;
      s_cnt      <= 3;
      s_addr     <= req_addr_o;
      if (req_write_o) remote[req_addr_o[3:0]] <= req_wdata_o;
    end else if (eng_busy_i) begin
      if (s_cnt == 1) begin
        eng_busy_i <= 1'b0;
        done_i     <= 1'b1;
        rdata_i    <= remote[s_addr[3:0]];
      end
      s_cnt <= s_cnt - 1;
    end
  end

  // scoreboard: expected transactions reaching the engine
  logic [31:0] exp_q [$];
  int          n_hs = 0;

  always @(negedge clk) begin
    if (rst_n && req_o && ack_i) begin
      n_hs++;
      if (exp_q.size() == 0) begin
        chk("R8 unexpected transaction", {req_write_o, req_addr_o, req_wdata_o}, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R2 transaction fields", {req_write_o, req_addr_o, e[31] ? req_wdata_o : 16'h0},
            {e[31:16], e[31] ? e[15:0] : 16'h0});
      end
    end
  end

  task automatic host_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    hw_valid = 1'b1; hw_sel = sel; hw_data = d;
    @(negedge clk);
    hw_valid = 1'b0;
  endtask

  task automatic issue(input bit wr, input logic [14:0] a, input logic [15:0] d, input bit expect_go);
    if (expect_go) begin
      exp_q.push_back({wr, a, d});
      if (wr) model[a[3:0]] = d;
    end
    host_wr(2'd2, {wr, a, d});
  endtask

  task automatic wait_state(input logic [2:0] s, input string tag);
    int k = 0;
    while (status_o[18:16] !== s && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk(tag, {29'h0, status_o[18:16]}, {29'h0, s});
  endtask

  task automatic do_read(input logic [14:0] a);
    logic [15:0] e;
    e = model[a[3:0]];
    issue(1'b0, a, 16'h0, 1'b1);
    wait_state(3'd6, "R6 read parks in state 6");
    chk("R6 read data", {16'h0, status_o[15:0]}, {16'h0, e});
    repeat (4) @(negedge clk);
    chk("R6 data held", {13'h0, status_o[18:16], status_o[15:0]}, {13'h0, 3'd6, e});
    host_wr(2'd3, 32'h0);
    chk("R7 clear with bit0=0 ignored", {29'h0, status_o[18:16]}, 32'd6);
    host_wr(2'd3, 32'h1);
    chk("R7 clear returns idle", {29'h0, status_o[18:16]}, 32'd0);
    chk("R6 data still shown after clear", {16'h0, status_o[15:0]}, {16'h0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status_o, 32'h0010_0000);
    chk("R1 no request after reset", {31'h0, req_o}, 32'h0);

    // disabled port ignores commands
    issue(1'b1, 15'h0003, 16'h1234, 1'b0);
    repeat (8) @(negedge clk);
    chk("R8 disabled command ignored", {29'h0, status_o[18:16]}, 32'd0);
    chk("R8 no transaction when disabled", n_hs, 0);

    host_wr(2'd1, 32'h1);
    chk("R10 init-done set", {31'h0, status_o[21]}, 32'h1);
    host_wr(2'd1, 32'h0);
    chk("R10 init-done cleared", {31'h0, status_o[21]}, 32'h0);
    host_wr(2'd1, 32'h1);
    host_wr(2'd0, 32'h1);

    // write transaction, with a second command while busy
    issue(1'b1, 15'h0005, 16'hBEEF, 1'b1);
    chk("R3 request state", {29'h0, status_o[18:16]}, 32'd2);
    chk("R3 pending and sync flags", {30'h0, status_o[19], status_o[20]}, 32'h2);
    chk("R2 address on engine port", {17'h0, req_addr_o}, 32'h0005);
    chk("R2 write flag and data", {15'h0, req_write_o, req_wdata_o}, {15'h0, 1'b1, 16'hBEEF});
    issue(1'b1, 15'h0007, 16'h1111, 1'b0);
    wait_state(3'd4, "R4 waits for engine");
    chk("R9 sync-idle low while busy", {31'h0, status_o[20]}, 32'h0);
    wait_state(3'd0, "R5 write returns idle");
    repeat (2) @(negedge clk);
    chk("R9 sync-idle high when quiet", {31'h0, status_o[20]}, 32'h1);

    do_read(15'h0005);
    host_wr(2'd3, 32'h1);
    chk("R7 clear in idle has no effect", status_o[21:16], 6'h30);
    do_read(15'h0002);
    do_read(15'h0007);

    issue(1'b1, 15'h7FFF, 16'h0001, 1'b1);
    chk("R2 full-width address", {17'h0, req_addr_o}, 32'h7FFF);
    wait_state(3'd0, "R5 second write idle");
    do_read(15'h7FFF);

    // disable again: command dropped
    host_wr(2'd0, 32'h0);
    issue(1'b0, 15'h0001, 16'h0, 1'b0);
    repeat (8) @(negedge clk);
    chk("R8 disabled read ignored", {29'h0, status_o[18:16]}, 32'd0);

    chk("R8 transaction count", n_hs, 6);
    chk("R2 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule